// File: doc/BRIEF.md
# Result FIFO With Overflow Policy

This block is a small synchronous queue that sits between a data converter and a register-read interface. The converter side pushes each finished result, and a read strobe from the register side pops the oldest held result into a registered read-data output. The block reports how many results it holds and raises three interrupt flags for a downstream interrupt controller to mask.

A one-bit policy input decides what a push into a full queue does. With policy 0 the new result is dropped. With policy 1 the oldest result is evicted to make room for it. Either way the sticky overflow flag is set. A two-bit level input sets the data-valid threshold: the data-valid flag is high while the queue holds more results than the level value, so the threshold runs from one to four results. A pop from an empty queue leaves the read data unchanged and sets a sticky underflow flag.

Top module: `result_fifo`

## Requirements
- R1: After reset the count is 0, read data is 0, and the data-valid, overflow and underflow flags are all low.
- R2: Results leave in the order they arrived. A pop on a non-empty queue presents the oldest result on `rd_data_o` from the clock edge that takes the pop, and the count reflects each push and pop at that same edge.
- R3: With `policy_i` = 0, a push without a pop into a queue holding DEPTH results is discarded. The count stays at DEPTH and the held results are unchanged.
- R4: With `policy_i` = 1, a push without a pop into a full queue drops the oldest result and appends the new one. The count stays at DEPTH.
- R5: A push without a pop into a full queue sets `ovf_irq_o` at the next edge under either policy. The flag then stays high until it is cleared.
- R6: `ovf_clr_i` high at an edge clears the overflow flag. If an overflow happens at the same edge, the flag stays set. `udf_clr_i` clears the underflow flag in the same way.
- R7: `dv_irq_o` is high exactly when the count is at least `level_i`+1 (level 0..3 gives threshold 1..4). It falls without any clear as soon as the count drops below the threshold.
- R8: A push and a pop at the same edge on a full queue is not an overflow. The count stays at DEPTH, the oldest result is read out and the new one is stored.
- R9: A pop on an empty queue leaves `rd_data_o` unchanged and sets the sticky `udf_irq_o`. A push at that same edge is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Store `push_data_i` |
| push_data_i | input | DATA_W | Result from the converter |
| pop_i | input | 1 | Read strobe from the register side |
| policy_i | input | 1 | Full-queue action: 0 drop new, 1 evict oldest |
| level_i | input | 2 | Data-valid threshold minus one |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |
| udf_clr_i | input | 1 | Write-one clear of the underflow flag |
| rd_data_o | output | DATA_W | Last popped result |
| count_o | output | CNT_W | Number of held results |
| dv_irq_o | output | 1 | Data-valid interrupt |
| ovf_irq_o | output | 1 | Sticky overflow interrupt |
| udf_irq_o | output | 1 | Sticky underflow interrupt |

## Verification
The bench builds the block with its defaults: a depth of 4 and a 12-bit result. At depth 4, all four level settings can be reached, including the top threshold, which needs a completely full queue. A full queue is reached in four pushes, so directed runs of each overflow policy and of simultaneous push and pop at full are short. Random traffic then revisits the full and empty boundaries often, with the policy, level and clear inputs changing from cycle to cycle.

// File: rtl/result_fifo.sv
module result_fifo #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              policy_i,
  input  logic [1:0]        level_i,
  input  logic              ovf_clr_i,
  input  logic              udf_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              dv_irq_o,
  output logic              ovf_irq_o,
  output logic              udf_irq_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  wire empty    = (count_o == '0);
  wire full     = (count_o == CNT_W'(DEPTH));
  wire do_pop   = pop_i && !empty;
  wire overflow = push_i && full && !do_pop;
  wire evict    = overflow && policy_i;
  wire do_write = push_i && (!full || do_pop || policy_i);
  wire grow     = do_write && !evict;

  assign dv_irq_o = (count_o > CNT_W'(level_i));

  always_ff @(posedge clk) begin
    if (do_write) mem[wptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count_o   <= '0;
      rd_data_o <= '0;
      ovf_irq_o <= 1'b0;
      udf_irq_o <= 1'b0;
    end else begin
      if (do_write)        wptr <= wptr + 1'b1;
      if (do_pop || evict) rptr <= rptr + 1'b1;
      if (do_pop)          rd_data_o <= mem[rptr];
      if (grow && !do_pop)      count_o <= count_o + 1'b1;
      else if (!grow && do_pop) count_o <= count_o - 1'b1;
      ovf_irq_o <= overflow | (ovf_irq_o & ~ovf_clr_i);
      udf_irq_o <= (pop_i & empty) | (udf_irq_o & ~udf_clr_i);
    end
  end

endmodule

// File: rtl/result_fifo_chk.sv
module result_fifo_chk #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic              policy_i,
  input logic              ovf_clr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              dv_irq_o,
  input logic              ovf_irq_o,
  input logic              udf_irq_o
);

  wire full  = (count_o == CNT_W'(DEPTH));
  wire empty = (count_o == '0);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));

  p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_i && !pop_i && !policy_i |=> full && $stable(rd_data_o));

  p_evict_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_i && !pop_i && policy_i |=> full);

  p_ovf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_i && !pop_i |=> ovf_irq_o);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq_o && !ovf_clr_i |=> ovf_irq_o);

  p_dv_at_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> dv_irq_o);

  p_dv_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !dv_irq_o);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && push_i && pop_i && !ovf_irq_o |=> !ovf_irq_o && full);

  p_udf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop_i |=> udf_irq_o && $stable(rd_data_o));

endmodule

bind result_fifo result_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
  .policy_i(policy_i), .ovf_clr_i(ovf_clr_i), .rd_data_o(rd_data_o),
  .count_o(count_o), .dv_irq_o(dv_irq_o), .ovf_irq_o(ovf_irq_o),
  .udf_irq_o(udf_irq_o)
);

// File: tb/sim_result_fifo.sv
`timescale 1ns/1ps
module sim_result_fifo;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_i = 0, pop_i = 0, policy_i = 0, ovf_clr_i = 0, udf_clr_i = 0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic [1:0] level_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic [CNT_W-1:0]  count_o;
  logic dv_irq_o, ovf_irq_o, udf_irq_o;

  always #2 clk = ~clk;

  result_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  string req = "R1";

  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] m_rd = '0;
  bit m_ovf = 0, m_udf = 0;

  task automatic chk(string r, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(req, "count", count_o, q.size());
    chk(req, "rd_data", rd_data_o, m_rd);
    chk("R7", "dv_irq", dv_irq_o, q.size() > int'(level_i));
    chk("R5", "ovf_irq", ovf_irq_o, m_ovf);
    chk("R9", "udf_irq", udf_irq_o, m_udf);
  endtask

  task automatic model_step();
    bit popped;
    bit ovf_now;
    popped = 0;
    ovf_now = 0;
    if (pop_i && q.size() > 0) begin
      m_rd = q.pop_front();
      popped = 1;
    end
    if (push_i) begin
      if (q.size() < DEPTH) q.push_back(push_data_i);
      else begin
        ovf_now = 1;
        if (policy_i) begin
          void'(q.pop_front());
          q.push_back(push_data_i);
        end
      end
    end
    m_ovf = ovf_now || (m_ovf && !ovf_clr_i);
    m_udf = (pop_i && !popped) || (m_udf && !udf_clr_i);
  endtask

  // apply inputs for one cycle at the negedge, step the model, then check at the next negedge
  task automatic cyc(bit ps, logic [DATA_W-1:0] d, bit pp, bit pol = policy_i,
                     logic [1:0] lv = level_i, bit oc = 0, bit uc = 0);
    push_i = ps; push_data_i = d; pop_i = pp; policy_i = pol;
    level_i = lv; ovf_clr_i = oc; udf_clr_i = uc;
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    chk("R1", "reset count", count_o, 0);
    chk("R1", "reset rd_data", rd_data_o, 0);
    chk("R1", "reset dv", dv_irq_o, 0);
    chk("R1", "reset ovf", ovf_irq_o, 0);
    chk("R1", "reset udf", udf_irq_o, 0);

    req = "R2";
    for (int i = 0; i < 3; i++) cyc(1, 12'h100 + 12'(i), 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1);

    req = "R3";
    for (int i = 0; i < 6; i++) cyc(1, 12'h200 + 12'(i), 0, 0, 3);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1);

    req = "R6";
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R6", "ovf cleared", ovf_irq_o, 0);

    req = "R4";
    for (int i = 0; i < 7; i++) cyc(1, 12'h300 + 12'(i), 0, 1, 2);
    req = "R6";
    cyc(1, 12'h3AA, 0, 1, 2, 1, 0);
    chk("R6", "set wins over clear", ovf_irq_o, 1);
    cyc(0, 0, 0, 1, 2, 1, 0);
    req = "R8";
    cyc(1, 12'h4AB, 1, 0, 3);
    chk("R8", "no ovf on push+pop full", ovf_irq_o, 0);
    cyc(1, 12'h4AC, 1, 1, 3);
    req = "R4";
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0);

    req = "R9";
    cyc(0, 0, 1);
    chk("R9", "udf set", udf_irq_o, 1);
    cyc(1, 12'h5A5, 1, 0, 0, 0, 1);
    chk("R9", "push kept on empty pop", count_o, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 1);

    req = "R7";
    for (int lv = 0; lv < 4; lv++) begin
      for (int i = 0; i < 4; i++) cyc(1, 12'(lv * 16 + i), 0, 0, 2'(lv));
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 2'(lv));
    end

    req = "R2";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 3) != 0, 12'($urandom), ($urandom % 2) == 0,
          ($urandom % 2) == 1, 2'($urandom), ($urandom % 8) == 0,
          ($urandom % 8) == 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule